// File: doc/BRIEF.md
# Flash Fetch Accelerator Controller

This block sits between a processor fetch port and a slow flash array. It keeps one buffered flash line for instruction fetches and one for data reads. It checks each processor request against these lines. A request that matches a held line is answered in the cycle it is presented. A request that does not match goes to the flash. That access is held open for a programmable number of processor clocks, and the line that comes back may then be kept for later requests.

Software uses two byte-wide registers. The acceleration register at offset 0x0 picks one of three levels: off, instruction only, or instruction and data. The wait register at offset 0x4 sets the flash access length in clocks, from 1 to 7. When the acceleration level changes, both held lines are dropped, so stale flash contents are never returned after a reconfiguration.

The processor holds `cpu_req`, `cpu_is_data` and `cpu_addr` steady until `cpu_ready` is seen. `cpu_addr` is a word address. Each flash line is `WORDS` words wide, and the flash returns the whole line for `fl_addr` = `cpu_addr` with the word-offset bits removed.

Top module: `flash_accel_ctrl`

## Requirements
- R1: After reset, offset 0x0 reads 0x00 (acceleration off) and offset 0x4 reads 0x07 (slowest access).
- R2: Bits [1:0] at offset 0x0 select the level: 00 off, 01 instruction only, 10 instruction and data. A write of 11 leaves the level unchanged and drops no line.
- R3: Bits [2:0] at offset 0x4 set the access length N in clocks. A write of 000 stores 1, and the register then reads back 0x01.
- R4: A request that misses raises `fl_req` in each of its cycles and gets `cpu_ready` in its Nth cycle, counting the first request cycle as cycle 1. With N = 1 it is answered in the first cycle. `cpu_rdata` is the addressed word of `fl_rdata`, where word w is `fl_rdata[w*DATA_W +: DATA_W]`.
- R5: With acceleration off, every request goes to the flash and takes N cycles, even one that repeats an address. No line is kept.
- R6: At level 01, an instruction fetch (`cpu_is_data`=0) to the held instruction line is answered in its first cycle with `fl_req` low. Data reads always go to the flash and are never kept.
- R7: At level 10, instruction fetches and data reads each hit their own held line. A line fetched for one kind of access does not serve the other kind.
- R8: A write to offset 0x0 that changes the level drops both held lines. A write of the level already in force drops nothing.
- R9: A miss to a new line replaces the held line of its own kind, so the previous line misses afterwards.
- R10: Reads of any offset other than 0x0 and 0x4 return 0. Unused upper bits of both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_is_data | input | 1 | 1 = data read, 0 = instruction fetch |
| cpu_addr | input | ADDR_W | Word address |
| cpu_ready | output | 1 | Request answered this cycle |
| cpu_rdata | output | DATA_W | Returned word, valid with `cpu_ready` |
| fl_req | output | 1 | Flash access in progress |
| fl_addr | output | ADDR_W-log2(WORDS) | Flash line address |
| fl_rdata | input | DATA_W*WORDS | Flash line data |

## Verification
The hardest case is a level change that arrives while both lines hold valid data. The flush can only be observed when a later request that would otherwise hit takes the full miss time instead. The stimulus first fills both lines at level 10 and confirms single-cycle hits. It then writes the same level and the reserved code 11, and expects the hits to remain. Finally it writes a new level and expects the next request to the same line to take N cycles. A bench model tracks level, wait count, held tags and elapsed miss cycles, and it compares ready, flash request, data and register readback on every clock.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_INSN = 2'b01,
    LVL_ALL  = 2'b10
  } acc_lvl_e;

  localparam logic [1:0] LVL_RSVD = 2'b11;
endpackage

// File: rtl/fa_regs.sv
module fa_regs
  import fa_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int TIM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output acc_lvl_e          lvl,
  output logic [TIM_W-1:0]  wait_len,
  output logic              flush
);
  localparam logic [REG_AW-1:0] OFS_LVL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_TIM = REG_AW'(4);

  acc_lvl_e         lvl_q, lvl_d;
  logic [TIM_W-1:0] tim_q, tim_d;
  logic             lvl_we, tim_we;

  always_comb begin
    lvl_d  = lvl_q;
    tim_d  = tim_q;
    flush  = 1'b0;
    lvl_we = reg_wr && (reg_addr == OFS_LVL) && (reg_wdata[1:0] != LVL_RSVD)
             && (reg_wdata[1:0] != lvl_q);
    tim_we = reg_wr && (reg_addr == OFS_TIM);
    if (lvl_we) begin
      lvl_d = acc_lvl_e'(reg_wdata[1:0]);
      flush = 1'b1;
    end
    if (tim_we) begin
      tim_d = (reg_wdata[TIM_W-1:0] == '0) ? TIM_W'(1) : reg_wdata[TIM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_OFF;
      tim_q <= '1;
    end else begin
      if (lvl_we) lvl_q <= lvl_d;
      if (tim_we) tim_q <= tim_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == OFS_LVL) reg_rdata = {6'b0, lvl_q};
    else if (reg_addr == OFS_TIM) reg_rdata = 8'(tim_q);
  end

  assign lvl      = lvl_q;
  assign wait_len = tim_q;

  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q != LVL_RSVD); // R2
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_LVL && reg_wdata[1:0] == LVL_RSVD) |=> $stable(lvl_q)); // R2
  AST_TIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tim_q != '0); // R3
endmodule

// File: rtl/fa_timer.sv
module fa_timer #(
  parameter int TIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [TIM_W-1:0] limit,
  output logic             done
);
  localparam int CW = TIM_W + 1;

  logic [TIM_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]    elapsed;

  always_comb begin
    elapsed = {1'b0, cnt_q} + CW'(1);
    done    = active && (elapsed >= {1'b0, limit});
    cnt_d   = (active && !done) ? cnt_q + TIM_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_IDLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || done) |=> cnt_q == '0); // R4
endmodule

// File: rtl/fa_line_buf.sv
module fa_line_buf #(
  parameter int TAG_W  = 14,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [LINE_W-1:0] line_in,
  output logic              hit,
  output logic [LINE_W-1:0] line_out
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    valid_d = valid_q;
    if (fill)  valid_d = 1'b1;
    if (flush) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (fill) begin
        tag_q  <= tag_in;
        line_q <= line_in;
      end
    end
  end

  assign hit      = valid_q && (tag_q == tag_in);
  assign line_out = line_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid_q); // R8
endmodule

// File: rtl/flash_accel_ctrl.sv
module flash_accel_ctrl
  import fa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int TIM_W  = 3,
  parameter int REG_AW = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int LINE_W  = DATA_W * WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               cpu_req,
  input  logic               cpu_is_data,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               fl_req,
  output logic [LINE_AW-1:0] fl_addr,
  input  logic [LINE_W-1:0]  fl_rdata
);
  localparam int NBUF = 2; // index 0: instruction line, 1: data line

  acc_lvl_e         lvl;
  logic [TIM_W-1:0] wait_len;
  logic             flush, done, hit;
  logic [LINE_AW-1:0] line_tag;
  logic [OFF_W-1:0]   word_idx;
  logic [NBUF-1:0]    buf_hit, buf_use, buf_fill;
  logic [LINE_W-1:0]  buf_line [NBUF];
  logic [LINE_W-1:0]  line_sel;

  fa_regs #(.REG_AW(REG_AW), .TIM_W(TIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl(lvl),
    .wait_len(wait_len), .flush(flush)
  );

  assign line_tag = cpu_addr[ADDR_W-1:OFF_W];
  assign word_idx = cpu_addr[OFF_W-1:0];

  always_comb begin
    buf_use[0]  = !cpu_is_data && (lvl != LVL_OFF);
    buf_use[1]  =  cpu_is_data && (lvl == LVL_ALL);
    buf_fill[0] = done && buf_use[0];
    buf_fill[1] = done && buf_use[1];
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    fa_line_buf #(.TAG_W(LINE_AW), .LINE_W(LINE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fill(buf_fill[g]),
      .tag_in(line_tag), .line_in(fl_rdata), .hit(buf_hit[g]),
      .line_out(buf_line[g])
    );
  end

  assign hit     = cpu_req && |(buf_hit & buf_use);
  assign fl_req  = cpu_req && !hit;
  assign fl_addr = line_tag;

  fa_timer #(.TIM_W(TIM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(fl_req), .limit(wait_len), .done(done)
  );

  always_comb begin
    if (hit) line_sel = cpu_is_data ? buf_line[1] : buf_line[0];
    else     line_sel = fl_rdata;
    cpu_rdata = line_sel[word_idx*DATA_W +: DATA_W];
    cpu_ready = hit || done;
  end

  AST_OFF_ALL_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && lvl == LVL_OFF) |-> fl_req); // R5
  AST_INSN_LVL_DATA_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_is_data && lvl == LVL_INSN) |-> fl_req); // R6
  AST_SINGLE_CLK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && wait_len == TIM_W'(1)) |-> cpu_ready); // R4
  AST_HIT_NEEDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !fl_req) |-> (lvl != LVL_OFF)); // R7
endmodule

// File: tb/flash_accel_ctrl_bench.sv
module flash_accel_ctrl_bench;
  localparam int ADDR_W = 16, DATA_W = 32, WORDS = 4, TIM_W = 3, REG_AW = 4;
  localparam int LINE_AW = ADDR_W - 2, LINE_W = DATA_W * WORDS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cpu_req = 1'b0, cpu_is_data = 1'b0, cpu_ready, fl_req;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic [LINE_AW-1:0] fl_addr;
  logic [LINE_W-1:0] fl_rdata;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  flash_accel_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .TIM_W(TIM_W), .REG_AW(REG_AW)) u_flash_accel_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
    .cpu_is_data(cpu_is_data), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] word_of(logic [15:0] a);
    return 32'h5A00_0000 ^ {a, a ^ 16'h3C3C};
  endfunction

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      fl_rdata[w*DATA_W +: DATA_W] = word_of({fl_addr, 2'(w)});
  end

  // behavioural reference state
  int m_lvl, m_tim, m_itag, m_dtag, m_wait;
  bit m_iv, m_dv;
  bit e_hit, e_flreq, e_done, e_ready;
  int e_rd;

  always_comb begin
    int line;
    line = int'(cpu_addr) / WORDS;
    e_hit = cpu_req && ((!cpu_is_data && m_lvl != 0 && m_iv && m_itag == line) ||
                        (cpu_is_data && m_lvl == 2 && m_dv && m_dtag == line));
    e_flreq = cpu_req && !e_hit;
    e_done  = e_flreq && (m_wait + 1 >= m_tim);
    e_ready = e_hit || e_done;
    e_rd = (reg_addr == 0) ? m_lvl : (reg_addr == 4) ? m_tim : 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_tim = 7; m_iv = 0; m_dv = 0; m_itag = 0; m_dtag = 0; m_wait = 0;
    end else begin
      int line;
      bit fl;
      line = int'(cpu_addr) / WORDS;
      fl = 0;
      if (e_done && !cpu_is_data && m_lvl != 0) begin m_iv = 1; m_itag = line; end
      if (e_done && cpu_is_data && m_lvl == 2) begin m_dv = 1; m_dtag = line; end
      m_wait = (e_flreq && !e_done) ? m_wait + 1 : 0;
      if (reg_wr && reg_addr == 0 && reg_wdata[1:0] != 2'b11 && int'(reg_wdata[1:0]) != m_lvl) begin
        m_lvl = int'(reg_wdata[1:0]); fl = 1;
      end
      if (reg_wr && reg_addr == 4) m_tim = (reg_wdata[2:0] == 0) ? 1 : int'(reg_wdata[2:0]);
      if (fl) begin m_iv = 0; m_dv = 0; end
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare against the model every cycle, 2 ns after the falling edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      check(phase, int'(cpu_ready), int'(e_ready), "cpu_ready");
      check(phase, int'(fl_req), int'(e_flreq), "fl_req");
      check(phase, int'(reg_rdata), e_rd, "reg_rdata");
      if (e_ready) check(phase, int'(cpu_rdata), int'(word_of(cpu_addr)), "cpu_rdata");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = REG_AW'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(string tag, int a, int exp);
    @(negedge clk);
    reg_addr = REG_AW'(a);
    #3;
    check(tag, int'(reg_rdata), exp, "register readback");
  endtask

  task automatic access(string tag, bit isd, int a, int exp_lat);
    int n;
    bit r;
    phase = tag;
    @(negedge clk);
    cpu_req = 1'b1; cpu_is_data = isd; cpu_addr = ADDR_W'(a);
    n = 0;
    do begin
      #3;
      n++;
      r = cpu_ready;
      if (r) check(tag, int'(cpu_rdata), int'(word_of(ADDR_W'(a))), "returned word");
      @(negedge clk);
    end while (!r && n < 40);
    cpu_req = 1'b0;
    check(tag, n, exp_lat, "ready latency");
  endtask

  initial begin
    #23 rst_n = 1'b1;
    rd_reg("R1", 0, 0);
    rd_reg("R1", 4, 7);
    // R4 and R3: every wait length in off mode
    for (int t = 7; t >= 1; t--) begin
      wr_reg(4, t);
      rd_reg("R3", 4, t);
      access("R4", 0, 16 + t, t);
    end
    wr_reg(4, 8'hF8); // low bits 000
    rd_reg("R3", 4, 1);
    access("R4", 1, 5, 1);
    // R5: off mode never keeps a line
    wr_reg(4, 3);
    access("R5", 0, 16, 3);
    access("R5", 0, 16, 3);
    access("R5", 1, 16, 3);
    // R6: instruction-only level
    wr_reg(0, 1);
    rd_reg("R2", 0, 1);
    access("R6", 0, 16, 3);
    access("R6", 0, 17, 1);
    access("R6", 1, 16, 3);
    access("R6", 1, 16, 3);
    // R7: both kinds, separate lines
    wr_reg(0, 2);
    access("R8", 0, 16, 3);
    access("R7", 1, 64, 3);
    access("R7", 1, 65, 1);
    access("R7", 0, 64, 3);
    access("R7", 0, 66, 1);
    // R9: replacement
    access("R9", 0, 128, 3);
    access("R9", 0, 64, 3);
    access("R9", 1, 67, 1);
    // R8 / R2: same level and reserved code keep lines
    wr_reg(0, 2);
    access("R8", 1, 64, 1);
    access("R8", 0, 65, 1);
    wr_reg(0, 3);
    rd_reg("R2", 0, 2);
    access("R2", 1, 66, 1);
    wr_reg(0, 1);
    access("R8", 0, 64, 3);
    wr_reg(0, 2);
    access("R8", 1, 64, 3);
    // R10: unused offsets and upper bits
    wr_reg(4, 8'hFE);
    rd_reg("R10", 4, 6);
    rd_reg("R10", 8, 0);
    rd_reg("R10", 2, 0);
    rd_reg("R10", 0, 2);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule